// File: doc/BRIEF.md
# Jitter Attenuator Elastic Store

This block is a bit-serial elastic buffer. Bits arrive on a write strobe whose timing carries jitter. They leave on a read strobe that is smoother, because a digital phase accumulator generates it inside the block. Everything runs on one fast system clock. The strobes are single-cycle enables in that clock domain.

The same block serves a transmit path or a receive path. Only the origin of the write strobe changes between the two. The usable depth is chosen from eight sizes, 16 to 128 entries in steps of 16.

The read pointer is placed back at mid-depth in three cases: after reset, when the depth selection changes, and when the centring input is toggled. When the fill level drifts to within a few entries of either end, the read strobe is retuned by 1/16 of a bit period, slower near empty and faster near full. This steers the fill back toward the centre. A true overflow or underflow sets a sticky slip flag and forces a re-centre.

Top module: `jitter_elastic_store`

## Requirements
- R1: The fill level reads depth/2 on the cycle after reset ends, after any change of `depth_sel`, and after any toggle of `centre_tgl`, where depth = 16 × (`depth_sel` + 1). While reset is held, fill reads 0.
- R2: With 4 ≤ fill ≤ depth − 4, the read strobe pulses exactly 16 times in every 128 consecutive clocks. That is one bit period of 8 clocks. `rd_stb` is never high on two consecutive cycles.
- R3: While fill > depth − 4, the read strobe pulses exactly 17 times per 128 clocks and `corr_active` is 1.
- R4: While fill < 4, the read strobe pulses exactly 15 times per 128 clocks and `corr_active` is 1.
- R5: After a re-centre, the first depth/2 read strobes carry the idle value 1. The following strobes return the bits written after that re-centre, in write order and without loss.
- R6: Write strobes that carry sinusoidal timing jitter with a peak below half the depth (in bit periods) at the nominal rate cause no slip.
- R7: A read with fill 0, or a write with fill = depth and no read in the same cycle, sets `slip_flag` and re-centres the fill to depth/2. Outside a re-centre, the fill moves by at most 1 per cycle and never exceeds depth.
- R8: `slip_flag` stays set until a `slip_clr` pulse clears it on the next cycle.
- R9: After fill is pushed above depth − 4 and writes resume at the nominal rate, the fast correction brings fill back to at most depth − 4. `corr_active` then drops, with no slip.
- R10: `corr_active` is 0 while 4 ≤ fill ≤ depth − 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| depth_sel | input | 3 | Depth code; depth = 16 × (code + 1) |
| centre_tgl | input | 1 | Any level change requests a re-centre |
| wr_stb | input | 1 | Write strobe, one cycle per incoming bit |
| wr_bit | input | 1 | Incoming data bit |
| slip_clr | input | 1 | Clears the sticky slip flag |
| rd_stb | output | 1 | De-jittered read strobe |
| rd_bit | output | 1 | Outgoing data bit, valid with `rd_stb` |
| fill_lvl | output | 8 | Current number of buffered bits |
| corr_active | output | 1 | Rate correction in force |
| slip_flag | output | 1 | Sticky overflow or underflow indicator |

## Verification
A corrupted pointer or fill count shows at the ports within one read period. It appears as a wrong bit in the ordered output stream, or as a fill reading that differs from depth/2 right after a re-centre. A wrong phase step shows only as a count of read strobes over a full 128-clock window, so rate faults are detected one window after the fill settles. A missed boundary condition surfaces as a slip many bit periods later, or as a fill that fails to return inside the thresholds.

// File: rtl/jes_pkg.sv
package jes_pkg;
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_SLOW = 2'd1,
    CORR_FAST = 2'd2
  } corr_e;

  // Usable depth for a selection code.
  function automatic int unsigned depth_of(input int unsigned sel, input int unsigned step);
    return step * (sel + 1);
  endfunction

  // Phase advance per clock, in 1/sub of a bit period per clock of the bit.
  function automatic int unsigned phase_inc(input corr_e c, input int unsigned sub);
    case (c)
      CORR_SLOW: return sub - 1;
      CORR_FAST: return sub + 1;
      default:   return sub;
    endcase
  endfunction

  function automatic logic near_low(input int unsigned fill, input int unsigned thr);
    return fill < thr;
  endfunction

  function automatic logic near_high(input int unsigned fill, input int unsigned depth,
                                     input int unsigned thr);
    return fill + thr > depth;
  endfunction
endpackage

// File: rtl/jes_rate.sv
module jes_rate #(
  parameter int UI_CLKS = 8,
  parameter int SUB     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  jes_pkg::corr_e corr,
  output logic          tick
);
  timeunit 1ns; timeprecision 100ps;

  localparam int UI_TICKS = UI_CLKS * SUB;
  localparam int ACC_W    = $clog2(UI_TICKS + SUB + 2);

  logic [ACC_W-1:0] acc, acc_sum, inc;

  always_comb begin
    inc     = ACC_W'(jes_pkg::phase_inc(corr, SUB));
    acc_sum = acc + inc;
    tick    = (acc_sum >= ACC_W'(UI_TICKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (tick) acc <= acc_sum - ACC_W'(UI_TICKS);
    else           acc <= acc_sum;
  end
endmodule

// File: rtl/jes_level.sv
module jes_level #(
  parameter int FILL_W = 8,
  parameter int THRESH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recentre_req,
  input  logic              wr_stb,
  input  logic              tick,
  input  logic              slip_clr,
  input  logic [FILL_W-1:0] depth,
  input  logic [FILL_W-1:0] half,
  output logic [FILL_W-1:0] fill,
  output logic              slip_flag,
  output logic              slip_evt,
  output logic              recentre,
  output logic              do_wr,
  output logic              do_rd,
  output logic              idle_rd,
  output jes_pkg::corr_e    corr
);
  timeunit 1ns; timeprecision 100ps;

  logic [FILL_W-1:0] stale;
  logic underflow, overflow;

  always_comb begin
    underflow = tick && (fill == '0);
    overflow  = wr_stb && !tick && (fill == depth);
    slip_evt  = (underflow || overflow) && !recentre_req;
    recentre  = recentre_req || slip_evt;
    do_wr     = wr_stb && !recentre;
    do_rd     = tick && !recentre;
    idle_rd   = recentre || (stale != '0);
    if (jes_pkg::near_low(32'(fill), THRESH))
      corr = jes_pkg::CORR_SLOW;
    else if (jes_pkg::near_high(32'(fill), 32'(depth), THRESH))
      corr = jes_pkg::CORR_FAST;
    else
      corr = jes_pkg::CORR_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill      <= '0;
      stale     <= '0;
      slip_flag <= 1'b0;
    end else begin
      if (recentre) begin
        fill  <= half;
        stale <= half;
      end else begin
        fill <= fill + FILL_W'(do_wr) - FILL_W'(do_rd);
        if (do_rd && stale != '0) stale <= stale - 1'b1;
      end
      slip_flag <= slip_evt || (slip_flag && !slip_clr);
    end
  end
endmodule

// File: rtl/jes_store.sv
module jes_store #(
  parameter int MAX_DEPTH = 128,
  parameter int PTR_W     = 7,
  parameter int FILL_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recentre,
  input  logic [FILL_W-1:0] depth,
  input  logic [FILL_W-1:0] half,
  input  logic              do_wr,
  input  logic              wr_bit,
  input  logic              do_rd,
  output logic              rd_data
);
  timeunit 1ns; timeprecision 100ps;

  logic [MAX_DEPTH-1:0] mem;
  logic [PTR_W-1:0]     wr_ptr, rd_ptr, last;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [PTR_W-1:0] lim);
    return (p == lim) ? '0 : p + 1'b1;
  endfunction

  assign last    = PTR_W'(depth - 1'b1);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (recentre) begin
      wr_ptr <= '0;
      rd_ptr <= PTR_W'(half);
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr, last);
      if (do_rd) rd_ptr <= bump(rd_ptr, last);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_bit;
  end
endmodule

// File: rtl/jitter_elastic_store.sv
module jitter_elastic_store #(
  parameter int   DEPTH_STEP = 16,
  parameter int   SEL_W      = 3,
  parameter int   UI_CLKS    = 8,
  parameter int   SUB        = 16,
  parameter int   THRESH     = 4,
  parameter logic IDLE_BIT   = 1'b1,
  localparam int  MAX_DEPTH  = DEPTH_STEP * (1 << SEL_W),
  localparam int  FILL_W     = $clog2(MAX_DEPTH + 1),
  localparam int  PTR_W      = $clog2(MAX_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  depth_sel,
  input  logic              centre_tgl,
  input  logic              wr_stb,
  input  logic              wr_bit,
  input  logic              slip_clr,
  output logic              rd_stb,
  output logic              rd_bit,
  output logic [FILL_W-1:0] fill_lvl,
  output logic              corr_active,
  output logic              slip_flag
);
  timeunit 1ns; timeprecision 100ps;

  logic [SEL_W-1:0]  sel_q;
  logic              centre_q, boot;
  logic [FILL_W-1:0] depth, half;
  logic              recentre_req, recentre, slip_evt, tick;
  logic              do_wr, do_rd, idle_rd, rd_data;
  jes_pkg::corr_e    corr;

  always_comb begin
    depth = FILL_W'(jes_pkg::depth_of(32'(depth_sel), DEPTH_STEP));
    half  = depth >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      centre_q <= 1'b0;
      boot     <= 1'b1;
    end else begin
      sel_q    <= depth_sel;
      centre_q <= centre_tgl;
      boot     <= 1'b0;
    end
  end

  assign recentre_req = boot || (depth_sel != sel_q) || (centre_tgl != centre_q);
  assign corr_active  = (corr != jes_pkg::CORR_NONE);

  jes_rate #(.UI_CLKS(UI_CLKS), .SUB(SUB)) u_rate (
    .clk(clk), .rst_n(rst_n), .corr(corr), .tick(tick)
  );

  jes_level #(.FILL_W(FILL_W), .THRESH(THRESH)) u_level (
    .clk(clk), .rst_n(rst_n), .recentre_req(recentre_req), .wr_stb(wr_stb),
    .tick(tick), .slip_clr(slip_clr), .depth(depth), .half(half),
    .fill(fill_lvl), .slip_flag(slip_flag), .slip_evt(slip_evt),
    .recentre(recentre), .do_wr(do_wr), .do_rd(do_rd), .idle_rd(idle_rd),
    .corr(corr)
  );

  jes_store #(.MAX_DEPTH(MAX_DEPTH), .PTR_W(PTR_W), .FILL_W(FILL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .recentre(recentre), .depth(depth), .half(half),
    .do_wr(do_wr), .wr_bit(wr_bit), .do_rd(do_rd), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb <= 1'b0;
      rd_bit <= IDLE_BIT;
    end else begin
      rd_stb <= tick;
      if (tick) rd_bit <= idle_rd ? IDLE_BIT : rd_data;
    end
  end
endmodule

// File: rtl/jes_checker.sv
module jes_checker #(
  parameter int FILL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              recentre,
  input logic              slip_evt,
  input logic              slip_clr,
  input logic              slip_flag,
  input logic              rd_stb,
  input logic [FILL_W-1:0] fill_lvl,
  input logic [FILL_W-1:0] depth
);
  timeunit 1ns; timeprecision 100ps;

  AST_RECENTRE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    recentre |=> (fill_lvl == ($past(depth) >> 1))); // R1

  AST_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R2

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !recentre |-> (fill_lvl <= depth)); // R7

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !recentre |=> (({1'b0, fill_lvl} <= {1'b0, $past(fill_lvl)} + 1'b1) &&
                   ({1'b0, fill_lvl} + 1'b1 >= {1'b0, $past(fill_lvl)}))); // R7

  AST_SLIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |=> slip_flag); // R7

  AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_flag && !slip_clr) |=> slip_flag); // R8
endmodule

bind jitter_elastic_store jes_checker #(.FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .recentre(recentre), .slip_evt(slip_evt),
  .slip_clr(slip_clr), .slip_flag(slip_flag), .rd_stb(rd_stb),
  .fill_lvl(fill_lvl), .depth(depth)
);

// File: tb/jitter_elastic_store_test.sv
module jitter_elastic_store_test;
  timeunit 1ns; timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n, centre_tgl, wr_stb, wr_bit, slip_clr;
  logic [2:0] depth_sel;
  logic       rd_stb, rd_bit, corr_active, slip_flag;
  logic [7:0] fill_lvl;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  jitter_elastic_store uut (
    .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .centre_tgl(centre_tgl),
    .wr_stb(wr_stb), .wr_bit(wr_bit), .slip_clr(slip_clr), .rd_stb(rd_stb),
    .rd_bit(rd_bit), .fill_lvl(fill_lvl), .corr_active(corr_active),
    .slip_flag(slip_flag)
  );

  // Vector table: depth code, jitter peak (clocks), bits, expected slips.
  localparam int NV = 5;
  localparam int VSEL [NV] = '{0, 1, 3, 7, 2};
  localparam int VAMP [NV] = '{12, 4, 16, 24, 0};
  localparam int VBITS[NV] = '{200, 240, 260, 300, 200};
  localparam int VSLIP[NV] = '{0, 0, 0, 0, 0};

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic logic pat(input int n);
    return logic'(((n * 37) >> 3) & 1);
  endfunction

  // Write time of bit n: nominal 8-clock period plus sinusoidal offset.
  function automatic int wtime(input int n, input int amp);
    real ph;
    ph = 2.0 * 3.14159265 * n / 32.0;
    return 8 + 8 * n + int'(amp * $sin(ph));
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic start_recentre(input int sel);
    depth_sel  = 3'(sel);
    centre_tgl = ~centre_tgl;
    slip_clr   = 1'b1;
    wr_stb     = 1'b0;
    step();
    slip_clr   = 1'b0;
  endtask

  // Each read is answered by one write on the following edge.
  task automatic mirror(input int ncyc, output int reads, output int corr_seen);
    reads = 0; corr_seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      wr_stb = rd_stb;
      step();
      if (rd_stb) reads++;
      if (corr_active) corr_seen++;
    end
    wr_stb = 1'b0;
  endtask

  task automatic run_vec(input int v);
    int half, nw, nr, tw, mism, slips, data_rd, cyc_end, k;
    logic exp_bit;
    half = 8 * (VSEL[v] + 1);
    start_recentre(VSEL[v]);
    nw = 0; nr = 0; mism = 0; slips = 0; data_rd = 0;
    tw = wtime(0, VAMP[v]);
    cyc_end = wtime(VBITS[v] - 1, VAMP[v]) + 4;
    for (int cyc = 0; cyc < cyc_end; cyc++) begin
      if (nw < VBITS[v] && cyc == tw) begin
        wr_stb = 1'b1; wr_bit = pat(nw); nw++; tw = wtime(nw, VAMP[v]);
      end else wr_stb = 1'b0;
      step();
      if (rd_stb) begin
        k = nr - half;
        exp_bit = (k < 0) ? 1'b1 : pat(k);
        if (k >= 0) data_rd++;
        if (rd_bit !== exp_bit) mism++;
        nr++;
      end
      if (slip_flag) slips = 1;
    end
    wr_stb = 1'b0;
    check($sformatf("R5 vector %0d idle then ordered data mismatches", v), mism, 0);
    check($sformatf("R5 vector %0d enough data bits read", v),
          int'(data_rd >= VBITS[v] - 2 * half), 1);
    check($sformatf("R6 vector %0d slips under jitter", v), slips, VSLIP[v]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int reads, corr_seen, found, waited;
    rst_n = 1'b0; depth_sel = 3'd0; centre_tgl = 1'b0;
    wr_stb = 1'b0; wr_bit = 1'b0; slip_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 fill during reset", int'(fill_lvl), 0);
    check("R7 slip flag during reset", int'(slip_flag), 0);
    check("R2 no read strobe during reset", int'(rd_stb), 0);
    rst_n = 1'b1;
    step();
    check("R1 fill after reset", int'(fill_lvl), 8);

    for (int v = 0; v < NV; v++) run_vec(v);

    // Depth changes re-centre.
    start_recentre(7);
    check("R1 fill at depth 128", int'(fill_lvl), 64);
    start_recentre(3);
    check("R1 fill at depth 64", int'(fill_lvl), 32);
    check("R10 no correction at mid fill", int'(corr_active), 0);

    // Nominal rate.
    start_recentre(0);
    mirror(32, reads, corr_seen);
    mirror(128, reads, corr_seen);
    check("R2 reads per 128 clocks nominal", reads, 16);
    check("R10 correction cycles at nominal fill", corr_seen, 0);

    // Forced high fill: fast correction.
    start_recentre(0);
    wr_stb = 1'b1;
    for (int i = 0; i < 7; i++) step();
    wr_stb = 1'b0;
    mirror(32, reads, corr_seen);
    check("R3 fill above upper threshold", int'(fill_lvl > 8'd12), 1);
    mirror(128, reads, corr_seen);
    check("R3 reads per 128 clocks fast", reads, 17);
    check("R3 correction flag held", corr_seen, 128);

    // Convergence with nominal writes.
    found = 0;
    for (int c = 0; c < 2000 && !found; c++) begin
      wr_stb = (c % 8 == 0);
      step();
      if (!corr_active) found = 1;
    end
    wr_stb = 1'b0;
    check("R9 correction released", found, 1);
    check("R9 fill back within thresholds", int'(fill_lvl >= 8'd4 && fill_lvl <= 8'd12), 1);
    check("R9 no slip during convergence", int'(slip_flag), 0);

    // Centre toggle without depth change.
    start_recentre(0);
    check("R1 fill after centre toggle", int'(fill_lvl), 8);

    // Forced low fill: slow correction.
    waited = 0;
    while (fill_lvl > 8'd2 && waited < 200) begin step(); waited++; end
    mirror(32, reads, corr_seen);
    check("R4 fill below lower threshold", int'(fill_lvl < 8'd4), 1);
    mirror(128, reads, corr_seen);
    check("R4 reads per 128 clocks slow", reads, 15);
    check("R4 correction flag held", corr_seen, 128);

    // Underflow.
    start_recentre(0);
    found = 0;
    for (int c = 0; c < 300 && !found; c++) begin
      step();
      if (slip_flag) found = 1;
    end
    check("R7 underflow sets slip", found, 1);
    check("R7 underflow re-centres fill", int'(fill_lvl), 8);
    repeat (3) step();
    check("R8 slip flag sticky", int'(slip_flag), 1);
    slip_clr = 1'b1;
    step();
    slip_clr = 1'b0;
    check("R8 slip flag cleared", int'(slip_flag), 0);

    // Overflow.
    start_recentre(0);
    wr_stb = 1'b1;
    found = 0;
    for (int c = 0; c < 100 && !found; c++) begin
      step();
      if (slip_flag) found = 1;
    end
    wr_stb = 1'b0;
    check("R7 overflow sets slip", found, 1);
    check("R7 overflow re-centres fill", int'(fill_lvl), 8);

    finish_run();
  end
endmodule